// File: doc/BRIEF.md
# Scalar float32 reciprocal unit

This block returns an approximate reciprocal of one IEEE-754 single-precision value and places it in the low 32-bit lane of a 128-bit result. The three upper lanes of the result are copied from a separate 128-bit source. A mask bit decides whether the low lane is written. When it is not written, a mode bit selects between keeping the value the low lane held before the operation and clearing it to zero.

A one-cycle start pulse hands over the operands, and a one-cycle done pulse marks a valid result together with its invalid and divide-by-zero flags. Operands in the normal range go through a sequential restoring mantissa divider and are then rounded to nearest-even. Zeros, denormals, infinities, NaNs, exact powers of two and inputs whose reciprocal would be denormal are resolved from a fixed table in a single cycle. Denormals are always flushed, both at the input and at the output, and no flag is raised for a flush.

Top module: `sp_recip_lane`

## Requirements
- R1: For an operand with exponent field 1..252 and a nonzero fraction, the low lane is a normal float32 of the same sign, and its relative error against the exact reciprocal is below 2^-23.
- R2: An operand equal to ±2^k with exponent field 1..253 and zero fraction returns exactly ±2^-k. For example, 0x00800000 returns 0x7E800000, and 0x7E800000 returns 0x00800000.
- R3: An operand with exponent field 0 (a zero or a denormal) returns 0x7F800000 when its sign bit is 0 and 0xFF800000 when its sign bit is 1, and raises the divide-by-zero flag.
- R4: An infinity (exponent field 255, zero fraction), an exponent field of 254, or an exponent field of 253 with a nonzero fraction returns a zero carrying the operand's sign, with both flags clear.
- R5: A NaN (exponent field 255, nonzero fraction) returns the operand with bit 22 set. The invalid flag is 1 exactly when bit 22 of the operand was 0.
- R6: When the mask bit is 1, the low lane receives the reciprocal. When the mask bit is 0 and the zeroing bit is 1, the low lane becomes 0.
- R7: When the mask bit is 0 and the zeroing bit is 0, the low lane keeps the value the result output held before the operation. After reset, that value is 0.
- R8: Result bits 127:32 equal src_a_i bits 127:32 as sampled with start, whatever the mask bit is.
- R9: Done is high for a single cycle. A special-case operand has its result ready in the cycle right after the clock edge that sampled start. A normal operand has it 27 edges after that edge. Start is ignored while a normal operation is in progress.
- R10: Both flags are 0 when the mask bit is 0. After reset, done, both flags and the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that samples the operands |
| src_a_i | input | 128 | Source of the three upper result lanes |
| src_b_i | input | 32 | Scalar float32 operand |
| mask_i | input | 1 | 1 writes the low lane |
| zero_mode_i | input | 1 | With mask 0: 1 clears the low lane, 0 keeps it |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | 128 | Result vector, held until the next completion |
| flag_inv_o | output | 1 | Invalid: the operand was a signaling NaN |
| flag_dz_o | output | 1 | Divide by zero: the operand was a zero or a denormal |

## Verification
The assertions assume that start arrives only when the unit is idle, or else that it is dropped. They also assume the divider is only ever given a divisor with a nonzero fraction, which keeps the partial remainder below twice the divisor. The bench raises start only after the previous done has been seen, and its normal-path operands all have exponent fields between 1 and 252 with nonzero fractions. Every boundary exponent (0, 1, 253, 254, 255) is reached through directed special-case vectors.

// File: rtl/sp_recip_pkg.sv
package sp_recip_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int LANE_W = 128;
  localparam int UP_W   = LANE_W - FP_W;
  localparam int DEN_W  = FRAC_W + 1;
  localparam int QUO_W  = FRAC_W + 3;

  typedef enum logic [2:0] {
    CLS_NORM,
    CLS_POW2,
    CLS_ZERO,
    CLS_INF,
    CLS_HUGE,
    CLS_NAN
  } fp_cls_e;
endpackage

// File: rtl/sp_recip_classify.sv
module sp_recip_classify
  import sp_recip_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output fp_cls_e         cls_o,
  output logic [FP_W-1:0] special_o,
  output logic            inv_o,
  output logic            dz_o
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  assign sgn = op_i[FP_W-1];
  assign ex  = op_i[FP_W-2:FRAC_W];
  assign fr  = op_i[FRAC_W-1:0];

  always_comb begin
    cls_o     = CLS_NORM;
    special_o = '0;
    inv_o     = 1'b0;
    dz_o      = 1'b0;
    if (ex == '1) begin
      if (fr != '0) begin
        cls_o     = CLS_NAN;
        special_o = op_i | (FP_W'(1) << (FRAC_W - 1));
        inv_o     = ~fr[FRAC_W-1];
      end else begin
        cls_o     = CLS_INF;
        special_o = {sgn, {(FP_W-1){1'b0}}};
      end
    end else if (ex == '0) begin
      cls_o     = CLS_ZERO;
      special_o = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      dz_o      = 1'b1;
    end else if ((ex == 8'd254) || ((ex == 8'd253) && (fr != '0))) begin
      cls_o     = CLS_HUGE;
      special_o = {sgn, {(FP_W-1){1'b0}}};
    end else if (fr == '0) begin
      cls_o     = CLS_POW2;
      special_o = {sgn, 8'd254 - ex, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/sp_recip_div.sv
module sp_recip_div #(
  parameter int DW = 24,
  parameter int QW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o,
  output logic          rem_nz_o
);
  localparam int RW = DW + 2;
  localparam int CW = $clog2(QW + 1);

  logic [RW-1:0] rem_q, rem_d;
  logic [DW-1:0] den_q, den_d;
  logic [QW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          ge;
  logic [RW-1:0] diff;

  assign ge   = rem_q >= {2'b00, den_q};
  assign diff = rem_q - {2'b00, den_q};

  always_comb begin
    rem_d  = rem_q;
    den_d  = den_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_i && !busy_q) begin
      rem_d  = {2'b01, {DW{1'b0}}};
      den_d  = den_i;
      quo_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      quo_d = {quo_q[QW-2:0], ge};
      rem_d = (ge ? diff : rem_q) << 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(QW - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done_o   = done_q;
  assign quo_o    = quo_q;
  assign rem_nz_o = |rem_q;

  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < {1'b0, den_q, 1'b0}));

  // R9
  div_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/sp_recip_round.sv
module sp_recip_round
  import sp_recip_pkg::*;
(
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [QUO_W-2:0] quo_i,
  input  logic             rem_nz_i,
  output logic [FP_W-1:0]  res_o
);
  logic            lsb, grd, stk, inc, carry;
  logic [FRAC_W:0] mant;
  logic [EXP_W-1:0] ex;

  always_comb begin
    lsb   = quo_i[2];
    grd   = quo_i[1];
    stk   = quo_i[0] | rem_nz_i;
    inc   = grd & (stk | lsb);
    mant  = {1'b0, quo_i[QUO_W-2:2]} + (FRAC_W+1)'(inc);
    carry = mant[FRAC_W];
    ex    = 8'd253 - exp_i + EXP_W'(carry);
    res_o = {sign_i, ex, carry ? {FRAC_W{1'b0}} : mant[FRAC_W-1:0]};
  end
endmodule

// File: rtl/sp_recip_lane.sv
module sp_recip_lane
  import sp_recip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LANE_W-1:0] src_a_i,
  input  logic [FP_W-1:0]   src_b_i,
  input  logic              mask_i,
  input  logic              zero_mode_i,
  output logic              done_o,
  output logic [LANE_W-1:0] result_o,
  output logic              flag_inv_o,
  output logic              flag_dz_o
);
  fp_cls_e           cls;
  logic [FP_W-1:0]   spec;
  logic              spec_inv, spec_dz;
  logic              accept, div_start, div_done, rem_nz;
  logic [QUO_W-1:0]  quo;
  logic [FP_W-1:0]   rnd;

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [LANE_W-1:0] res_q, res_d;
  logic              inv_q, inv_d, dz_q, dz_d;
  logic [UP_W-1:0]   upper_q, upper_d;
  logic              mask_q, mask_d, zero_q, zero_d, sign_q, sign_d;
  logic [EXP_W-1:0]  exp_q, exp_d;
  fp_cls_e           cls_q, cls_d;

  sp_recip_classify u_cls (
    .op_i     (src_b_i),
    .cls_o    (cls),
    .special_o(spec),
    .inv_o    (spec_inv),
    .dz_o     (spec_dz)
  );

  assign accept    = start_i && !busy_q;
  assign div_start = accept && (cls == CLS_NORM);

  sp_recip_div #(.DW(DEN_W), .QW(QUO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .den_i   ({1'b1, src_b_i[FRAC_W-1:0]}),
    .done_o  (div_done),
    .quo_o   (quo),
    .rem_nz_o(rem_nz)
  );

  sp_recip_round u_rnd (
    .sign_i  (sign_q),
    .exp_i   (exp_q),
    .quo_i   (quo[QUO_W-2:0]),
    .rem_nz_i(rem_nz),
    .res_o   (rnd)
  );

  function automatic logic [FP_W-1:0] pick_low(input logic [FP_W-1:0] val,
                                              input logic msk, input logic zm,
                                              input logic [FP_W-1:0] prev);
    if (msk)     return val;
    else if (zm) return '0;
    else         return prev;
  endfunction

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    res_d   = res_q;
    inv_d   = inv_q;
    dz_d    = dz_q;
    upper_d = upper_q;
    mask_d  = mask_q;
    zero_d  = zero_q;
    sign_d  = sign_q;
    exp_d   = exp_q;
    cls_d   = cls_q;
    if (accept) begin
      upper_d = src_a_i[LANE_W-1:FP_W];
      mask_d  = mask_i;
      zero_d  = zero_mode_i;
      sign_d  = src_b_i[FP_W-1];
      exp_d   = src_b_i[FP_W-2:FRAC_W];
      cls_d   = cls;
      if (cls != CLS_NORM) begin
        res_d  = {src_a_i[LANE_W-1:FP_W],
                  pick_low(spec, mask_i, zero_mode_i, res_q[FP_W-1:0])};
        inv_d  = mask_i & spec_inv;
        dz_d   = mask_i & spec_dz;
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
      end
    end else if (busy_q && div_done) begin
      res_d  = {upper_q, pick_low(rnd, mask_q, zero_q, res_q[FP_W-1:0])};
      inv_d  = 1'b0;
      dz_d   = 1'b0;
      done_d = 1'b1;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
      inv_q   <= 1'b0;
      dz_q    <= 1'b0;
      upper_q <= '0;
      mask_q  <= 1'b0;
      zero_q  <= 1'b0;
      sign_q  <= 1'b0;
      exp_q   <= '0;
      cls_q   <= CLS_NORM;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      res_q   <= res_d;
      inv_q   <= inv_d;
      dz_q    <= dz_d;
      upper_q <= upper_d;
      mask_q  <= mask_d;
      zero_q  <= zero_d;
      sign_q  <= sign_d;
      exp_q   <= exp_d;
      cls_q   <= cls_d;
    end
  end

  assign done_o     = done_q;
  assign result_o   = res_q;
  assign flag_inv_o = inv_q;
  assign flag_dz_o  = dz_q;

  // R8
  upper_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (res_q[LANE_W-1:FP_W] == upper_q));

  // R6
  zeroing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mask_q && zero_q) |-> (res_q[FP_W-1:0] == '0));

  // R7
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mask_q && !zero_q) |-> (res_q[FP_W-1:0] == $past(res_q[FP_W-1:0])));

  // R5
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mask_q && (cls_q == CLS_NAN)) |-> res_q[FRAC_W-1]);

  // R10
  flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !mask_q) |-> (!inv_q && !dz_q));

  // R1
  norm_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mask_q && (cls_q == CLS_NORM)) |->
      ((res_q[FP_W-2:FRAC_W] != '0) && (res_q[FP_W-2:FRAC_W] != '1)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: tb/sp_recip_lane_tb.sv
`timescale 1ns/1ps
module sp_recip_lane_tb;
  logic         clk;
  logic         rst_n;
  logic         start;
  logic [127:0] src_a;
  logic [31:0]  src_b;
  logic         mask;
  logic         zm;
  logic         done;
  logic [127:0] res;
  logic         finv, fdz;

  int n_chk  = 0;
  int n_fail = 0;

  sp_recip_lane u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .src_a_i    (src_a),
    .src_b_i    (src_b),
    .mask_i     (mask),
    .zero_mode_i(zm),
    .done_o     (done),
    .result_o   (res),
    .flag_inv_o (finv),
    .flag_dz_o  (fdz)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic real f2r(input logic [31:0] b);
    real m;
    m = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (real'(int'(b[30:23])) - 127.0));
    return b[31] ? -m : m;
  endfunction

  task automatic run_op(input logic [127:0] a, input logic [31:0] b, input logic mk,
                        input logic z, output int lat);
    @(negedge clk);
    src_a = a; src_b = b; mask = mk; zm = z; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 done never seen act=0 exp=1");
    end
  endtask

  task automatic t_reset;
    check("R10 reset result", res, 128'h0);
    check("R10 reset done", {127'h0, done}, 128'h0);
    check("R10 reset flags", {126'h0, finv, fdz}, 128'h0);
  endtask

  task automatic t_special(input string tag, input logic [31:0] b, input logic [31:0] exp,
                           input logic ei, input logic ed);
    int lat;
    logic [127:0] a;
    a = {32'hA5A5_0001, 32'h1234_5678, 32'h0BAD_F00D, 32'hFFFF_FFFF};
    run_op(a, b, 1'b1, 1'b0, lat);
    check({tag, " value"}, {96'h0, res[31:0]}, {96'h0, exp});
    check({tag, " flags"}, {126'h0, finv, fdz}, {126'h0, ei, ed});
    check("R9 special latency", 128'(lat), 128'd0);
    check("R8 upper lanes", {32'h0, res[127:32]}, {32'h0, a[127:32]});
  endtask

  task automatic t_specials;
    t_special("R2 2.0", 32'h4000_0000, 32'h3F00_0000, 0, 0);
    t_special("R2 -0.25", 32'hBE80_0000, 32'hC080_0000, 0, 0);
    t_special("R2 2^126", 32'h7E80_0000, 32'h0080_0000, 0, 0);
    t_special("R2 2^-126", 32'h0080_0000, 32'h7E80_0000, 0, 0);
    t_special("R3 +0", 32'h0000_0000, 32'h7F80_0000, 0, 1);
    t_special("R3 -denorm", 32'h8000_0001, 32'hFF80_0000, 0, 1);
    t_special("R3 +denorm", 32'h007F_FFFF, 32'h7F80_0000, 0, 1);
    t_special("R4 +inf", 32'h7F80_0000, 32'h0000_0000, 0, 0);
    t_special("R4 -inf", 32'hFF80_0000, 32'h8000_0000, 0, 0);
    t_special("R4 huge e253", 32'h7E80_0001, 32'h0000_0000, 0, 0);
    t_special("R4 huge e254", 32'hFF00_0000, 32'h8000_0000, 0, 0);
    t_special("R5 snan", 32'h7F80_0001, 32'h7FC0_0001, 1, 0);
    t_special("R5 qnan", 32'hFFC0_0005, 32'hFFC0_0005, 0, 0);
  endtask

  task automatic t_normal(input logic [31:0] b);
    int lat;
    real x, y, err;
    logic [127:0] a;
    a = {b, ~b, b ^ 32'h5A5A_5A5A, 32'h0};
    run_op(a, b, 1'b1, 1'b1, lat);
    check("R9 normal latency", 128'(lat), 128'd27);
    check("R1 sign", {127'h0, res[31]}, {127'h0, b[31]});
    n_chk++;
    if (res[30:23] == 8'h00 || res[30:23] == 8'hFF) begin
      n_fail++;
      $display("FAIL R1 not normal act=%h exp=normal", res[31:0]);
    end else begin
      x = f2r(b);
      y = f2r(res[31:0]);
      err = x * y - 1.0;
      if (err < 0.0) err = -err;
      if (err >= 2.0 ** -23.0) begin
        n_fail++;
        $display("FAIL R1 rel err act=%h exp=1/%h", res[31:0], b);
      end
    end
    check("R8 upper normal", {32'h0, res[127:32]}, {32'h0, a[127:32]});
    @(posedge clk);
    @(negedge clk);
    check("R9 done single cycle", {127'h0, done}, 128'h0);
  endtask

  task automatic t_normals;
    int lat;
    t_normal(32'h4040_0000);
    check("R1 1/3 rounded", {96'h0, res[31:0]}, {96'h0, 32'h3EAA_AAAB});
    t_normal(32'hBFC0_0000);
    t_normal(32'h3DCC_CCCD);
    t_normal(32'h7149_F2CA);
    t_normal(32'h40E0_0000);
    t_normal(32'h3FFF_FFFF);
    t_normal(32'h0080_0001);
    // R9: a start raised while busy is dropped
    @(negedge clk);
    src_b = 32'h4040_0000; mask = 1'b1; zm = 1'b0; start = 1'b1;
    @(posedge clk); @(negedge clk);
    src_b = 32'h0000_0000;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    check("R9 start ignored busy", {96'h0, res[31:0]}, {96'h0, 32'h3EAA_AAAB});
    check("R9 start ignored lat", 128'(lat), 128'd27);
    @(posedge clk); @(negedge clk);
    check("R9 no second done", {127'h0, done}, 128'h0);
  endtask

  task automatic t_masking;
    int lat;
    logic [127:0] a;
    a = {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h0};
    run_op(a, 32'h4040_0000, 1'b1, 1'b0, lat);
    check("R6 masked write", {96'h0, res[31:0]}, {96'h0, 32'h3EAA_AAAB});
    run_op(~a, 32'h0000_0000, 1'b0, 1'b0, lat);
    check("R7 merge special", {96'h0, res[31:0]}, {96'h0, 32'h3EAA_AAAB});
    check("R10 merge flags", {126'h0, finv, fdz}, 128'h0);
    check("R8 merge upper", {32'h0, res[127:32]}, {32'h0, ~a[127:32]});
    run_op(a, 32'h40E0_0000, 1'b0, 1'b0, lat);
    check("R7 merge normal", {96'h0, res[31:0]}, {96'h0, 32'h3EAA_AAAB});
    run_op(a, 32'h7F80_0001, 1'b0, 1'b1, lat);
    check("R6 zeroing special", {96'h0, res[31:0]}, 128'h0);
    check("R10 zeroing flags", {126'h0, finv, fdz}, 128'h0);
    run_op(a, 32'h4000_0000, 1'b1, 1'b0, lat);
    run_op(~a, 32'h40E0_0000, 1'b0, 1'b1, lat);
    check("R6 zeroing normal", {96'h0, res[31:0]}, 128'h0);
    check("R8 zeroing upper", {32'h0, res[127:32]}, {32'h0, ~a[127:32]});
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; src_a = '0; src_b = '0; mask = 1'b0; zm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    // R7: a merge straight after reset keeps the reset value 0
    rst_n = 1'b1;
    begin
      int lat;
      run_op(128'h0, 32'h4000_0000, 1'b0, 1'b0, lat);
      check("R7 merge after reset", {96'h0, res[31:0]}, 128'h0);
    end
    t_specials();
    t_normals();
    t_masking();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule